// File: doc/BRIEF.md
# Translation Fault Interrupt Controller

This block gathers error events from an address translation unit and turns them into a single interrupt line. Each of five event sources has a sticky status bit, and software clears a bit by writing a one to it. A per-event enable mask decides which pending events drive the interrupt. The block also records the details of the first faulting access: the virtual address, the requester's program counter, a transaction tag, the access direction and a request-info type. A separate register keeps the virtual address of the most recent miss caused by a debug access.

Software reaches the block through a simple single-cycle register port with combinational read data. The translation logic pulses one event line per fault and presents the capture fields in the same cycle. When the interrupt-disable control bit is set, faults raise no interrupt. Instead the block pulses an error-response output, which the requester's port returns as a bus error.

Top module: `xlat_fault_irq`

## Requirements
- R1: Event pulse bits map to status bits (offset 0) in a fixed order: bit 0 is a miss with the hardware walk disabled, bit 1 is an invalid descriptor, bit 2 is a miss during a debug access, bit 3 is an error response during a table walk, and bit 4 is a multiple-match. A pulse sets its bit on the next clock edge.
- R2: A status bit stays set until software writes 1 to that bit position at offset 0. Writing 0 leaves the bit unchanged.
- R3: If a pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R4: The enable register (offset 1) uses the same bit layout as the status register. The `irq` output is registered. One cycle after any status bit is set together with its enable bit (and interrupt-disable is clear), `irq` is 1. Otherwise `irq` is 0.
- R5: On an event, the fault address (offset 2, read-only) and the program counter (offset 4, read-only) load from the capture inputs. This happens only when no enabled status bit is already pending, so the first fault is preserved.
- R6: Whenever event bit 2 pulses, the debug fault address (offset 3, read-only) loads from `cap_va`.
- R7: The fault detail word at offset 5 holds the tag in bits 8:4, the direction in bit 3 (1 = read, 0 = write) and the type in bits 2:1. These fields are captured under the same rule as R5. Bit 0 is a fault flag that any event sets and a write of 1 clears, and the set wins over the clear.
- R8: Bit 0 at offset 6 is interrupt-disable. While it is 1, `irq` is 0, and each cycle with an event pulse is followed one cycle later by a one-cycle `err_resp` pulse. While it is 0, `err_resp` stays 0.
- R9: After reset, every register and output is 0. Unused bits, and reads from offset 7, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| evt_pulse | input | 5 | One-cycle fault event pulses |
| cap_va | input | 32 | Virtual address of faulting access |
| cap_pc | input | 32 | Requester program counter |
| cap_tag | input | 5 | Transaction tag |
| cap_rd | input | 1 | Direction, 1 = read |
| cap_type | input | 2 | Request-info type |
| irq | output | 1 | Interrupt line |
| err_resp | output | 1 | Error-response pulse for the requester |

## Verification
The bench builds the block with its default parameters: five events, a 32-bit address, a 5-bit tag and a 2-bit type. These sizes make every status, enable and capture bit observable at the register port. Within that width, random event patterns combined with random clear writes frequently produce same-cycle set/clear collisions. They also often produce second faults that arrive while a first enabled fault is still pending. Directed sequences force these collisions and the toggling of the interrupt-disable bit.

// File: rtl/xlat_fault_irq.sv
module xlat_fault_irq #(
  parameter int NEVT   = 5,
  parameter int VA_W   = 32,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  parameter int TYPE_W = 2,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NEVT-1:0]   evt_pulse,
  input  logic [VA_W-1:0]   cap_va,
  input  logic [DATA_W-1:0] cap_pc,
  input  logic [TAG_W-1:0]  cap_tag,
  input  logic              cap_rd,
  input  logic [TYPE_W-1:0] cap_type,
  output logic              irq,
  output logic              err_resp
);
  localparam int DBG_BIT  = 2;
  localparam int INFO_W   = TAG_W + 1 + TYPE_W + 1;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_VA   = AW'(2);
  localparam logic [AW-1:0] A_DBG  = AW'(3);
  localparam logic [AW-1:0] A_PC   = AW'(4);
  localparam logic [AW-1:0] A_INFO = AW'(5);
  localparam logic [AW-1:0] A_CTRL = AW'(6);

  logic [NEVT-1:0]   status_q, en_q;
  logic [VA_W-1:0]   fault_va_q, dbg_va_q;
  logic [DATA_W-1:0] fault_pc_q;
  logic [TAG_W-1:0]  tag_q;
  logic              rd_q, flag_q, dis_q;
  logic [TYPE_W-1:0] type_q;

  logic            any_evt, pend_en, capture;
  logic [NEVT-1:0] clr_mask;
  logic            flag_clr;

  assign any_evt  = |evt_pulse;
  assign pend_en  = |(status_q & en_q);
  assign capture  = any_evt & ~pend_en;
  assign clr_mask = (reg_we && reg_addr == A_STAT) ? reg_wdata[NEVT-1:0] : '0;
  assign flag_clr = reg_we && reg_addr == A_INFO && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      en_q       <= '0;
      fault_va_q <= '0;
      dbg_va_q   <= '0;
      fault_pc_q <= '0;
      tag_q      <= '0;
      rd_q       <= 1'b0;
      type_q     <= '0;
      flag_q     <= 1'b0;
      dis_q      <= 1'b0;
      irq        <= 1'b0;
      err_resp   <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_mask) | evt_pulse;
      flag_q   <= (flag_q & ~flag_clr) | any_evt;
      irq      <= pend_en & ~dis_q;
      err_resp <= any_evt & dis_q;
      if (reg_we && reg_addr == A_EN)   en_q  <= reg_wdata[NEVT-1:0];
      if (reg_we && reg_addr == A_CTRL) dis_q <= reg_wdata[0];
      if (evt_pulse[DBG_BIT]) dbg_va_q <= cap_va;
      if (capture) begin
        fault_va_q <= cap_va;
        fault_pc_q <= cap_pc;
        tag_q      <= cap_tag;
        rd_q       <= cap_rd;
        type_q     <= cap_type;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT: reg_rdata[NEVT-1:0]   = status_q;
      A_EN:   reg_rdata[NEVT-1:0]   = en_q;
      A_VA:   reg_rdata[VA_W-1:0]   = fault_va_q;
      A_DBG:  reg_rdata[VA_W-1:0]   = dbg_va_q;
      A_PC:   reg_rdata             = fault_pc_q;
      A_INFO: reg_rdata[INFO_W-1:0] = {tag_q, rd_q, type_q, flag_q};
      A_CTRL: reg_rdata[0]          = dis_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xlat_fault_irq_chk.sv
module xlat_fault_irq_chk #(
  parameter int NEVT   = 5,
  parameter int VA_W   = 32,
  parameter int DATA_W = 32,
  parameter int AW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NEVT-1:0]   evt_pulse,
  input logic              irq,
  input logic              err_resp,
  input logic [NEVT-1:0]   status_q,
  input logic [NEVT-1:0]   en_q,
  input logic              dis_q,
  input logic [VA_W-1:0]   fault_va_q
);
  // R1
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse)));
  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == AW'(0)) |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R4
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & en_q) == '0) |=> !irq);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & en_q)) |=> $stable(fault_va_q));
  // R8
  dis_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> !irq);
  // R8
  err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_q |=> !err_resp);
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(7)) |-> (reg_rdata == '0));
endmodule

bind xlat_fault_irq xlat_fault_irq_chk #(
  .NEVT(NEVT), .VA_W(VA_W), .DATA_W(DATA_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq),
  .err_resp(err_resp), .status_q(status_q), .en_q(en_q),
  .dis_q(dis_q), .fault_va_q(fault_va_q)
);

// File: tb/xlat_fault_irq_bench.sv
`timescale 1ns/1ps
module xlat_fault_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [4:0]  evt_pulse = '0;
  logic [31:0] cap_va = '0, cap_pc = '0;
  logic [4:0]  cap_tag = '0;
  logic        cap_rd = 1'b0;
  logic [1:0]  cap_type = '0;
  logic        irq, err_resp;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [4:0]  m_st, m_en, m_tag;
  logic [31:0] m_va, m_dbg, m_pc;
  logic        m_rd, m_flag, m_dis, m_irq, m_err;
  logic [1:0]  m_type;

  xlat_fault_irq u_xlat_fault_irq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .cap_va(cap_va), .cap_pc(cap_pc), .cap_tag(cap_tag), .cap_rd(cap_rd),
    .cap_type(cap_type), .irq(irq), .err_resp(err_resp)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] model_rd(input int a);
    case (a)
      0: return {27'd0, m_st};
      1: return {27'd0, m_en};
      2: return m_va;
      3: return m_dbg;
      4: return m_pc;
      5: return {23'd0, m_tag, m_rd, m_type, m_flag};
      6: return {31'd0, m_dis};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string reg_tag(input int a);
    case (a)
      0: return "R1";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R5";
      5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = '0; m_en = '0; m_tag = '0; m_va = '0; m_dbg = '0; m_pc = '0;
    m_rd = 0; m_flag = 0; m_dis = 0; m_irq = 0; m_err = 0; m_type = '0;
  endtask

  task automatic model_step();
    logic pend, cap;
    logic [4:0] clr;
    pend  = |(m_st & m_en);
    cap   = (|evt_pulse) && !pend;
    clr   = (reg_we && reg_addr == 3'd0) ? reg_wdata[4:0] : 5'd0;
    m_irq = pend && !m_dis;
    m_err = m_dis && (|evt_pulse);
    m_st  = (m_st & ~clr) | evt_pulse;
    m_flag = (m_flag & ~(reg_we && reg_addr == 3'd5 && reg_wdata[0])) | (|evt_pulse);
    if (evt_pulse[2]) m_dbg = cap_va;
    if (cap) begin
      m_va = cap_va; m_pc = cap_pc; m_tag = cap_tag; m_rd = cap_rd; m_type = cap_type;
    end
    if (reg_we && reg_addr == 3'd1) m_en = reg_wdata[4:0];
    if (reg_we && reg_addr == 3'd6) m_dis = reg_wdata[0];
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      reg_addr = a[2:0];
      #0.4;
      check(tag.len() > 0 ? tag : reg_tag(a), reg_rdata, model_rd(a));
    end
    check(tag.len() > 0 ? tag : "R4", {31'd0, irq}, {31'd0, m_irq});
    check(tag.len() > 0 ? tag : "R8", {31'd0, err_resp}, {31'd0, m_err});
  endtask

  task automatic cycle(input logic [4:0] ev, input logic we, input logic [2:0] ad,
                       input logic [31:0] wd, input logic [31:0] va);
    evt_pulse = ev; reg_we = we; reg_addr = ad; reg_wdata = wd;
    cap_va = va; cap_pc = ~va; cap_tag = va[4:0] ^ 5'h15;
    cap_rd = va[7]; cap_type = va[9:8];
    @(posedge clk);
    model_step();
    @(negedge clk);
    evt_pulse = '0; reg_we = 1'b0;
    check_all("");
  endtask

  task automatic rd_check(input string rq, input logic [2:0] ad, input logic [31:0] exp);
    reg_addr = ad;
    #0.4;
    check(rq, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9");

    cycle(5'd0, 1, 3'd1, 32'h1F, 32'h0);
    for (int i = 0; i < 5; i++) begin
      cycle(5'd1 << i, 0, 3'd0, 32'h0, 32'h1000 + i);
      rd_check("R1", 3'd0, 32'(5'd1 << i));
      cycle(5'd0, 1, 3'd0, 32'h0, 32'h0);
      rd_check("R2", 3'd0, 32'(5'd1 << i));
      cycle(5'd0, 1, 3'd0, 32'h1F, 32'h0);
      rd_check("R2", 3'd0, 32'h0);
    end

    cycle(5'b00001, 0, 3'd0, 0, 32'hA000_0000);
    cycle(5'b00001, 1, 3'd0, 32'h1, 32'hB000_0000);
    rd_check("R3", 3'd0, 32'h1);
    rd_check("R5", 3'd2, 32'hA000_0000);
    cycle(5'b10000, 0, 3'd0, 0, 32'hC000_0100);
    rd_check("R5", 3'd2, 32'hA000_0000);
    check("R4", {31'd0, irq}, 32'd1);
    cycle(5'b00100, 1, 3'd5, 32'h1, 32'hD000_0000);
    rd_check("R6", 3'd3, 32'hD000_0000);
    rd_check("R7", 3'd5, model_rd(5));
    cycle(5'd0, 1, 3'd0, 32'h1F, 0);
    cycle(5'd0, 1, 3'd5, 32'h1, 0);
    rd_check("R7", 3'd5, model_rd(5) & 32'hFFFF_FFFE);
    cycle(5'b01000, 0, 3'd0, 0, 32'hE000_0380);
    rd_check("R7", 3'd5, {23'd0, 5'h15 ^ 5'h00, 1'b1, 2'b11, 1'b1});

    cycle(5'd0, 1, 3'd6, 32'h1, 0);
    cycle(5'b00010, 0, 3'd0, 0, 32'h1234_5678);
    check("R8", {31'd0, err_resp}, 32'd1);
    check("R8", {31'd0, irq}, 32'd0);
    cycle(5'd0, 0, 3'd0, 0, 0);
    check("R8", {31'd0, err_resp}, 32'd0);
    cycle(5'd0, 1, 3'd6, 32'h0, 0);
    cycle(5'd0, 1, 3'd7, 32'hFFFF_FFFF, 0);
    rd_check("R9", 3'd7, 32'h0);

    for (int n = 0; n < 600; n++) begin
      logic [4:0] ev;
      logic we;
      ev = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      we = ($urandom % 3 == 0);
      cycle(ev, we, 3'($urandom), $urandom, $urandom);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule